// File: doc/BRIEF.md
# GPIO pin interrupt detector

This block watches one already-synchronized input pin and turns its transitions or levels into a latched status flag and an interrupt request. Software writes a configuration word through a simple write port. The word holds an interrupt enable, a raw-status enable, a polarity bit, a detection-mode field and a three-bit target field. Software clears an edge event by writing the status location. A parameter picks the acknowledge value: either a written 1 or a written 0 clears the flag.

A second parameter picks how the mode field is encoded. The two-bit form can sense a level, a rising edge, a falling edge or both edges. The one-bit form can sense only a level or a single edge, and the polarity picks which edge. Edges are found by comparing the polarity-adjusted pin with its value from the previous cycle. Because of this, flipping the polarity while the pin is steady also counts as an edge. The request leaves the block only when the interrupt is enabled, the flag is set and the target field selects the application-processor route.

Top module: `pin_irq_detect`

## Requirements
- R1: After synchronous reset, the configuration word and the status flag are zero, `status_o` and `irq_o` are low, and pin activity sets nothing.
- R2: With TWO_BIT_MODE=1 and polarity 1, the mode field (config bits 4:3) selects the edge: 1 senses rising, 2 senses falling, 3 senses both. A qualifying transition of the pin sets `status_o` at the next clock edge.
- R3: In level sensing (two-bit mode field 0, or config bit 3 = 0 in one-bit mode), while armed, `status_o` follows the active level every cycle. Polarity 1 means active-high and polarity 0 means active-low. An acknowledge cannot clear the flag while the level stays active.
- R4: With TWO_BIT_MODE=0, config bit 3 = 1 selects edge sensing and config bit 4 is ignored. Polarity 1 senses a rising edge and polarity 0 senses a falling edge. Both edges are never sensed together.
- R5: An edge status stays set until a write to address 1 whose data bit 0 equals the acknowledge value (1 when ACK_HIGH=1, 0 when ACK_HIGH=0). A write to address 1 with the other value leaves the flag set.
- R6: When a qualifying edge and an acknowledge fall in the same cycle, the flag is set afterwards.
- R7: In an edge mode with the pin steady, a polarity change that makes the adjusted input go from inactive to active sets the flag.
- R8: While both the enable (bit 0) and the raw-status enable (bit 1) are clear, pin events do not change the flag, and an acknowledge still clears it.
- R9: `irq_o` is high exactly when the enable bit is set, the flag is set and the target field (bits 7:5) equals 4. Any other target keeps `irq_o` low.
- R10: A write to address 0 loads the whole configuration word. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address: 0 config, 1 status |
| wr_data | input | DATA_W | Write data |
| pin_in | input | 1 | Synchronized pin level |
| status_o | output | 1 | Latched status flag |
| irq_o | output | 1 | Interrupt request on the application-processor route |

## Verification
The hardest case to reach is the false edge from a polarity change. The pin must sit still while only the configuration word changes, and the flag must be observed exactly one cycle after the write lands. The bench reaches it by reprogramming the polarity back and forth with the pin held, in both encodings. It also lines up a pin transition and an acknowledge write on the same clock edge. A behavioural model of both encodings and both acknowledge values runs beside two instances, and the two are compared every cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Configuration word layout, MSB first
    typedef struct packed {
        logic [2:0] target;   // routing select
        logic [1:0] mode;     // detection mode
        logic       pol;      // polarity
        logic       raw_en;   // raw-status enable
        logic       enable;   // interrupt enable
    } cfg_t;

    localparam int CFG_W      = $bits(cfg_t);
    localparam int TGT_W      = 3;
    localparam int TGT_APPS   = 4;
    localparam int REG_CFG    = 0;
    localparam int REG_STAT   = 1;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'd0,
        SENSE_RISE  = 2'd1,
        SENSE_FALL  = 2'd2,
        SENSE_BOTH  = 2'd3
    } sense_e;

    // Polarity-adjusted pin: 1 means the pin is at its active value
    function automatic logic adjusted_level(input logic pin, input logic pol);
        return pin ~^ pol;
    endfunction

    function automatic logic is_armed(input cfg_t c);
        return c.enable | c.raw_en;
    endfunction

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter bit ACK_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_q,
    output logic              ack_clr
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

    logic cfg_we;

    always_comb begin
        cfg_we  = wr_en && (wr_addr == A_CFG);
        ack_clr = wr_en && (wr_addr == A_STAT) && (wr_data[0] == ACK_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
    import pin_irq_pkg::*;
#(
    parameter bit TWO_BIT_MODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic       pol,
    input  logic [1:0] mode,
    output logic       lvl_mode,
    output logic       lvl_active,
    output logic       edge_hit
);
    logic   adj;
    logic   adj_prev_q;
    logic   rise;
    logic   fall;
    sense_e sel;

    always_comb begin
        adj  = adjusted_level(pin_in, pol);
        rise = adj & ~adj_prev_q;
        fall = ~adj & adj_prev_q;
    end

    // One-cycle-delayed copy of the adjusted input
    always_ff @(posedge clk) begin
        if (rst) begin
            adj_prev_q <= 1'b0;
        end else begin
            adj_prev_q <= adj;
        end
    end

    generate
        if (TWO_BIT_MODE) begin : g_two_bit
            always_comb sel = sense_e'(mode);
        end else begin : g_one_bit
            // bit 0 of the field picks edge; a single edge only
            always_comb sel = mode[0] ? SENSE_RISE : SENSE_LEVEL;
        end
    endgenerate

    always_comb begin
        lvl_mode   = (sel == SENSE_LEVEL);
        lvl_active = adj;
        unique case (sel)
            SENSE_RISE: edge_hit = rise;
            SENSE_FALL: edge_hit = fall;
            SENSE_BOTH: edge_hit = rise | fall;
            default:    edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic lvl_mode,
    input  logic lvl_active,
    input  logic edge_hit,
    input  logic ack_clr,
    output logic status_q
);
    logic status_d;

    always_comb begin
        if (armed && lvl_mode) begin
            status_d = lvl_active;
        end else if (armed) begin
            // a fresh edge outranks a simultaneous acknowledge
            status_d = edge_hit | (status_q & ~ack_clr);
        end else begin
            status_d = status_q & ~ack_clr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
        end else begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/pin_irq_route.sv
module pin_irq_route #(
    parameter int TGT_W    = 3,
    parameter int APPS_SEL = 4
) (
    input  logic             enable,
    input  logic             status,
    input  logic [TGT_W-1:0] target,
    output logic             irq
);
    localparam logic [TGT_W-1:0] SEL = TGT_W'(APPS_SEL);

    always_comb irq = enable & status & (target == SEL);

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pin_irq_pkg::*;
#(
    parameter int ADDR_W       = 2,
    parameter int DATA_W       = 8,
    parameter bit TWO_BIT_MODE = 1'b1,
    parameter bit ACK_HIGH     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pin_in,
    output logic              status_o,
    output logic              irq_o
);
    cfg_t cfg_q;
    logic ack_clr;
    logic lvl_mode;
    logic lvl_active;
    logic edge_hit;
    logic armed;

    pin_irq_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ACK_HIGH (ACK_HIGH)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .ack_clr (ack_clr)
    );

    pin_irq_sense #(
        .TWO_BIT_MODE (TWO_BIT_MODE)
    ) u_sense (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (pin_in),
        .pol        (cfg_q.pol),
        .mode       (cfg_q.mode),
        .lvl_mode   (lvl_mode),
        .lvl_active (lvl_active),
        .edge_hit   (edge_hit)
    );

    always_comb armed = is_armed(cfg_q);

    pin_irq_status u_status (
        .clk        (clk),
        .rst        (rst),
        .armed      (armed),
        .lvl_mode   (lvl_mode),
        .lvl_active (lvl_active),
        .edge_hit   (edge_hit),
        .ack_clr    (ack_clr),
        .status_q   (status_o)
    );

    pin_irq_route #(
        .TGT_W    (TGT_W),
        .APPS_SEL (TGT_APPS)
    ) u_route (
        .enable (cfg_q.enable),
        .status (status_o),
        .target (cfg_q.target),
        .irq    (irq_o)
    );

endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
    parameter int ADDR_W   = 2,
    parameter bit ACK_HIGH = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit0,
    input logic              pin_in,
    input logic              status_o,
    input logic              irq_o,
    input logic              en,
    input logic              raw_en,
    input logic              pol,
    input logic [2:0]        target,
    input logic              lvl_mode,
    input logic              edge_hit
);
    logic ack_now;
    logic armed;

    always_comb begin
        ack_now = wr_en && (wr_addr == ADDR_W'(1)) && (wr_bit0 == ACK_HIGH);
        armed   = en | raw_en;
    end

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status_o && en));

    p_route_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (target != 3'd4) |-> !irq_o);

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (status_o && !(armed && lvl_mode) && !ack_now) |=> status_o);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_now && !(armed && (lvl_mode || edge_hit))) |=> !status_o);

    p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && !lvl_mode && edge_hit) |=> status_o);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!armed && !ack_now) |=> $stable(status_o));

    p_level_track_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && lvl_mode && (pin_in == pol)) |=> status_o);

endmodule

bind pin_irq_detect pin_irq_detect_chk #(
    .ADDR_W   (ADDR_W),
    .ACK_HIGH (ACK_HIGH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit0  (wr_data[0]),
    .pin_in   (pin_in),
    .status_o (status_o),
    .irq_o    (irq_o),
    .en       (cfg_q.enable),
    .raw_en   (cfg_q.raw_en),
    .pol      (cfg_q.pol),
    .target   (cfg_q.target),
    .lvl_mode (lvl_mode),
    .edge_hit (edge_hit)
);

// File: tb/pin_irq_detect_test.sv
module pin_irq_detect_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we  [2];
    logic [1:0] ad  [2];
    logic [7:0] dat [2];
    logic       pin [2];
    logic       st_o  [2];
    logic       irq_o [2];

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    bit done    = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    // instance 0: two-bit encoding, acknowledge by writing 1
    pin_irq_detect #(.TWO_BIT_MODE(1'b1), .ACK_HIGH(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_en(we[0]), .wr_addr(ad[0]), .wr_data(dat[0]),
        .pin_in(pin[0]), .status_o(st_o[0]), .irq_o(irq_o[0]));

    // instance 1: one-bit encoding, acknowledge by writing 0
    pin_irq_detect #(.TWO_BIT_MODE(1'b0), .ACK_HIGH(1'b0)) uut_alt (
        .clk(clk), .rst(rst), .wr_en(we[1]), .wr_addr(ad[1]), .wr_data(dat[1]),
        .pin_in(pin[1]), .status_o(st_o[1]), .irq_o(irq_o[1]));

    // ---------------- behavioural reference ----------------
    int m_cfg  [2];
    bit m_prev [2];
    bit m_st   [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                m_cfg[i] = 0; m_prev[i] = 0; m_st[i] = 0;
            end else begin
                bit pol, act, rise, fall, lvl, hit, ack, armed;
                int md;
                pol   = m_cfg[i][2];
                act   = (pin[i] == pol);
                rise  = act && !m_prev[i];
                fall  = !act && m_prev[i];
                md    = (m_cfg[i] >> 3) & 3;
                if (i == 0) begin
                    lvl = (md == 0);
                    hit = (md == 1) ? rise : (md == 2) ? fall : (md == 3) ? (rise || fall) : 1'b0;
                end else begin
                    lvl = !m_cfg[i][3];
                    hit = m_cfg[i][3] && rise;
                end
                ack   = we[i] && ad[i] == 2'd1 && dat[i][0] == (i == 0);
                armed = m_cfg[i][0] || m_cfg[i][1];
                if (armed && lvl)  m_st[i] = act;
                else if (armed)    m_st[i] = hit || (m_st[i] && !ack);
                else               m_st[i] = m_st[i] && !ack;
                m_prev[i] = act;
                if (we[i] && ad[i] == 2'd0) m_cfg[i] = int'(dat[i]);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < 2; i++) begin
                bit ei;
                ei = m_cfg[i][0] && m_st[i] && (((m_cfg[i] >> 5) & 7) == 4);
                vectors++;
                if (st_o[i] !== m_st[i] || irq_o[i] !== ei) begin
                    misses++;
                    $display("FAIL %s model inst%0d: status=%b irq=%b expected status=%b irq=%b",
                             cur_req, i, st_o[i], irq_o[i], m_st[i], ei);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int i, input logic [1:0] a, input logic [7:0] d);
        we[i] = 1'b1; ad[i] = a; dat[i] = d;
        tick();
        we[i] = 1'b0;
    endtask

    task automatic chk(input int i, input logic es, input logic ei, input string tag);
        vectors++;
        if (st_o[i] !== es || irq_o[i] !== ei) begin
            misses++;
            $display("FAIL %s inst%0d: status=%b irq=%b expected status=%b irq=%b",
                     tag, i, st_o[i], irq_o[i], es, ei);
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            we[i] = 0; ad[i] = 0; dat[i] = 0; pin[i] = 0;
        end
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state, pin activity ignored
        cur_req = "R1";
        chk(0, 0, 0, "R1"); chk(1, 0, 0, "R1");
        pin[0] = 1; pin[1] = 1; tick();
        pin[0] = 0; pin[1] = 0; tick();
        chk(0, 0, 0, "R1"); chk(1, 0, 0, "R1");

        // ===== instance 0, two-bit encoding =====
        cur_req = "R2";
        wr(0, 0, 8'h8E); tick();          // rise, pol1, raw, target 4
        chk(0, 0, 0, "R2");
        pin[0] = 1; tick();
        chk(0, 1, 0, "R2 rising");
        cur_req = "R5";
        wr(0, 1, 8'h00);                  // wrong acknowledge value
        chk(0, 1, 0, "R5 non-ack write");
        cur_req = "R9";
        wr(0, 0, 8'h8F);                  // enable
        chk(0, 1, 1, "R9 enabled");
        cur_req = "R5";
        wr(0, 1, 8'h01);
        chk(0, 0, 0, "R5 ack");
        pin[0] = 0; tick();
        chk(0, 0, 0, "R2 fall ignored in rise mode");

        cur_req = "R2";
        wr(0, 0, 8'h97); tick();          // falling
        pin[0] = 1; tick();
        chk(0, 0, 0, "R2 rise ignored in fall mode");
        pin[0] = 0; tick();
        chk(0, 1, 1, "R2 falling");
        wr(0, 1, 8'h01);
        wr(0, 0, 8'h9F); tick();          // both edges
        pin[0] = 1; tick();
        chk(0, 1, 1, "R2 both rise");
        wr(0, 1, 8'h01);
        pin[0] = 0; tick();
        chk(0, 1, 1, "R2 both fall");
        wr(0, 1, 8'h01);
        chk(0, 0, 0, "R5 ack");

        // R6: edge and acknowledge on the same edge
        cur_req = "R6";
        pin[0] = 1; wr(0, 1, 8'h01);
        chk(0, 1, 1, "R6 edge beats ack");
        wr(0, 1, 8'h01);

        // R9: routing by target
        cur_req = "R9";
        wr(0, 0, 8'h7F); tick();          // target 3
        pin[0] = 0; tick();
        chk(0, 1, 0, "R9 target 3");
        wr(0, 0, 8'hBF);                  // target 5
        chk(0, 1, 0, "R9 target 5");
        wr(0, 0, 8'h9F);                  // target 4
        chk(0, 1, 1, "R9 target 4");

        // R10: writes to unused addresses change nothing
        cur_req = "R10";
        wr(0, 2, 8'h00);
        wr(0, 3, 8'h01);
        chk(0, 1, 1, "R10 unused address");
        wr(0, 1, 8'h01);

        // R3: level sensing
        cur_req = "R3";
        wr(0, 0, 8'h87); tick();          // level, active-high
        chk(0, 0, 0, "R3 inactive");
        pin[0] = 1; tick();
        chk(0, 1, 1, "R3 high level");
        wr(0, 1, 8'h01);
        chk(0, 1, 1, "R3 ack blocked by level");
        pin[0] = 0; tick();
        chk(0, 0, 0, "R3 level gone");
        wr(0, 0, 8'h83); tick();          // active-low
        chk(0, 1, 1, "R3 low level");
        pin[0] = 1; tick();
        chk(0, 0, 0, "R3 low level gone");

        // R7: polarity flip with steady pin
        cur_req = "R7";
        wr(0, 0, 8'h8A); tick();          // rise, pol0, raw only
        chk(0, 0, 0, "R7 setup");
        wr(0, 0, 8'h8E); tick();          // pol back to 1
        chk(0, 1, 0, "R7 polarity flip edge");
        wr(0, 1, 8'h01);
        chk(0, 0, 0, "R7 cleared");

        // R8: disarmed
        cur_req = "R8";
        wr(0, 0, 8'h8C); tick();
        pin[0] = 0; tick();
        pin[0] = 1; tick();
        chk(0, 0, 0, "R8 events ignored");
        wr(0, 0, 8'h8E); tick();
        pin[0] = 0; tick();
        pin[0] = 1; tick();
        chk(0, 1, 0, "R8 armed catch");
        wr(0, 0, 8'h8C); tick();
        pin[0] = 0; tick();
        chk(0, 1, 0, "R8 disarmed hold");
        wr(0, 1, 8'h01);
        chk(0, 0, 0, "R8 ack while disarmed");

        // ===== instance 1, one-bit encoding, acknowledge by 0 =====
        cur_req = "R4";
        wr(1, 0, 8'h8F); tick();          // edge, pol1 -> rising
        chk(1, 0, 0, "R4 setup");
        pin[1] = 1; tick();
        chk(1, 1, 1, "R4 rising");
        cur_req = "R5";
        wr(1, 1, 8'h01);
        chk(1, 1, 1, "R5 non-ack write");
        wr(1, 1, 8'h00);
        chk(1, 0, 0, "R5 ack by zero");
        cur_req = "R4";
        pin[1] = 0; tick();
        chk(1, 0, 0, "R4 falling ignored");
        cur_req = "R7";
        wr(1, 0, 8'h8B); tick();          // pol0, pin low -> adjusted rises
        chk(1, 1, 1, "R7 polarity flip edge");
        wr(1, 1, 8'h00);
        cur_req = "R4";
        pin[1] = 1; tick();
        chk(1, 0, 0, "R4 rise ignored with pol0");
        pin[1] = 0; tick();
        chk(1, 1, 1, "R4 falling");
        wr(1, 1, 8'h00);
        wr(1, 0, 8'h9F); tick();          // bit 4 set, still one edge
        chk(1, 0, 0, "R4 setup both");
        pin[1] = 1; tick();
        chk(1, 1, 1, "R4 rise");
        wr(1, 1, 8'h00);
        pin[1] = 0; tick();
        chk(1, 0, 0, "R4 no both-edge");
        cur_req = "R3";
        wr(1, 0, 8'h87); tick();          // level, active-high
        chk(1, 0, 0, "R3 inactive");
        pin[1] = 1; tick();
        chk(1, 1, 1, "R3 high level");
        wr(1, 1, 8'h00);
        chk(1, 1, 1, "R3 ack blocked by level");

        // R1: reset again clears everything
        cur_req = "R1";
        rst = 1'b1; tick(); rst = 1'b0; tick();
        chk(0, 0, 0, "R1 re-reset"); chk(1, 0, 0, "R1 re-reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule